// File: doc/BRIEF.md
# Banked GPIO Controller with Write-One Set/Clear

This block gives software control over a group of general-purpose pins through a small 32-bit register bus. Pins are arranged in banks of 32. Each bank has three write-one-to-act registers. One drives selected pins high, one drives them low, and one returns them to input mode. Writing a drive level also turns the pin into an output, so software never has to program the direction separately before driving a pin.

A read of a bank's value register returns the live, synchronized level of each pin, whether the pin is an input or an output. A separate read-only pair of words holds the levels of the low 64 pins. These levels are captured once, on the first clock after reset is released, and are never updated afterwards.

The address map has room for 128 pins. Only 75 are built. Bits for the missing pins read as zero and ignore writes.

Top module: `pinbank_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, every `pin_oe` bit is 0, every `pin_out` bit is 0, and `bus_rvalid` is 0.
- R2: Writing a 1 to bit j of the drive-high register (bank offset 0x00) sets `pin_out` and `pin_oe` of that pin at the write's clock edge. Bits written as 0 leave their pins unchanged.
- R3: Writing a 1 to bit j of the drive-low register (bank offset 0x04) clears `pin_out` and sets `pin_oe` of that pin at the write's clock edge. Bits written as 0 leave their pins unchanged.
- R4: Writing a 1 to bit j of the release register (bank offset 0x08) clears `pin_oe` of that pin and keeps its `pin_out` latch. Bits written as 0 leave their pins unchanged.
- R5: Pin n belongs to bank n/32 and sits at bit n%32. Bank k starts at byte address k*0x20. A write to one bank changes no pin of another bank.
- R6: Reading a bank's offset 0x00 returns the `pin_in` levels of that bank after a two-flop synchronizer. This holds for input pins and output pins alike.
- R7: Pins 75 to 127 are not built. Their bits read as 0 at every bank address, and writes to them, including any write to bank 3 (0x60 to 0x7F), change no output.
- R8: The words at 0x100 (pins 0 to 31) and 0x104 (pins 32 to 63) return the synchronized pin levels captured on the first clock after reset is released. They do not change afterwards, whatever the pins do.
- R9: `bus_rdata` and `bus_rvalid` are registered and appear one cycle after `bus_rd_en`. Offsets 0x04 and 0x08 read as 0, and so does any address outside the bank and snapshot windows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Write strobe, one cycle per write |
| bus_rd_en | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | ADDR_W (9) | Byte address; bits 1:0 are ignored |
| bus_wdata | input | 32 | Write data, one bit per pin of the bank |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | High the cycle after a read strobe |
| pin_in | input | NUM_PINS (75) | Pad levels as seen at the pins |
| pin_out | output | NUM_PINS (75) | Output latches |
| pin_oe | output | NUM_PINS (75) | Output enables, 1 = driven |

## Verification
The bench models the pads so that a driven pin reads back its own latch and an undriven pin reads an external pattern. The same value read therefore tells apart a direction bug from a latch bug.

Two different external patterns are read while all pins are inputs. This shows that the value path follows live levels and that bank words are not swapped. Set and clear writes use sparse masks over pins that are already driven, which shows that zero bits are truly left alone. An all-ones write to the last, partly built bank and to the empty fourth bank shows the edge of the built pins.

Later, the external pattern is changed and the snapshot words are read again. They are compared with the pattern that was present when reset was released, which separates a one-time capture from a live copy.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;

  localparam int unsigned REG_W = 32;

  // word offsets inside one bank window
  localparam int unsigned OFS_DRIVE_HI = 0;
  localparam int unsigned OFS_DRIVE_LO = 1;
  localparam int unsigned OFS_RELEASE  = 2;

  typedef enum logic [1:0] {
    OP_NONE,
    OP_HI,
    OP_LO,
    OP_REL
  } pin_op_e;

  // number of built pins that fall in the bank starting at pin lo
  function automatic int unsigned lanes_in_bank(int unsigned total,
                                                int unsigned lo,
                                                int unsigned width);
    if (total <= lo)
      return 0;
    else if (total - lo >= width)
      return width;
    else
      return total - lo;
  endfunction

endpackage

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    chain[0] <= din;
    for (int i = 1; i < STAGES; i++)
      chain[i] <= chain[i-1];
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/pinbank_lane.sv
module pinbank_lane
  import pinbank_pkg::*;
#(
  parameter int unsigned LANES = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  pin_op_e          op,
  input  logic [LANES-1:0] mask,
  output logic [LANES-1:0] out_q,
  output logic [LANES-1:0] oe_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= '0;
      oe_q  <= '0;
    end else begin
      unique case (op)
        OP_HI: begin
          out_q <= out_q | mask;
          oe_q  <= oe_q | mask;
        end
        OP_LO: begin
          out_q <= out_q & ~mask;
          oe_q  <= oe_q | mask;
        end
        OP_REL: begin
          oe_q  <= oe_q & ~mask;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/pinbank_snapshot.sv
module pinbank_snapshot #(
  parameter int unsigned WIDTH = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] smp,
  output logic [WIDTH-1:0] snap_q,
  output logic             done_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      snap_q <= '0;
      done_q <= 1'b0;
    end else if (!done_q) begin
      snap_q <= smp;
      done_q <= 1'b1;
    end
  end

endmodule

// File: rtl/pinbank_ctrl.sv
module pinbank_ctrl
  import pinbank_pkg::*;
#(
  parameter int unsigned NUM_PINS       = 75,
  parameter int unsigned MAX_PINS       = 128,
  parameter int unsigned SYNC_STAGES    = 2,
  parameter int unsigned SNAP_PINS      = 64,
  parameter int unsigned ADDR_W         = 9,
  parameter int unsigned BANK_STRIDE_LG = 5,
  parameter logic [ADDR_W-1:0] SNAP_BASE = 9'h100
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_wr_en,
  input  logic                bus_rd_en,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [REG_W-1:0]    bus_wdata,
  output logic [REG_W-1:0]    bus_rdata,
  output logic                bus_rvalid,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe
);

  localparam int unsigned BANK_W     = REG_W;
  localparam int unsigned NUM_BANKS  = MAX_PINS / BANK_W;
  localparam int unsigned BANK_SEL_W = $clog2(NUM_BANKS);
  localparam int unsigned OFS_W      = BANK_STRIDE_LG - 2;
  localparam int unsigned SNAP_W     = (SNAP_PINS < NUM_PINS) ? SNAP_PINS : NUM_PINS;
  localparam int unsigned SNAP_WORDS = SNAP_PINS / BANK_W;

  // ---------------- synchronizer ----------------
  logic [NUM_PINS-1:0] sync_val;
  logic [MAX_PINS-1:0] sync_ext;

  pinbank_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .din  (pin_in),
    .dout (sync_val)
  );

  assign sync_ext = MAX_PINS'(sync_val);

  // ---------------- power-up snapshot ----------------
  logic [SNAP_W-1:0]    snap_q;
  logic                 snap_done;
  logic [SNAP_PINS-1:0] snap_ext;

  pinbank_snapshot #(.WIDTH(SNAP_W)) u_snap (
    .clk    (clk),
    .rst    (rst),
    .smp    (sync_val[SNAP_W-1:0]),
    .snap_q (snap_q),
    .done_q (snap_done)
  );

  assign snap_ext = SNAP_PINS'(snap_q);

  // ---------------- address decode ----------------
  logic                  in_bank;
  logic                  in_snap;
  logic [BANK_SEL_W-1:0] bank_sel;
  logic [OFS_W-1:0]      ofs;
  logic [ADDR_W-1:0]     snap_off;
  pin_op_e               dec_op;

  assign in_bank  = bus_addr < ADDR_W'(NUM_BANKS << BANK_STRIDE_LG);
  assign in_snap  = (bus_addr >= SNAP_BASE) &&
                    (bus_addr < SNAP_BASE + ADDR_W'(SNAP_WORDS * 4));
  assign bank_sel = bus_addr[BANK_STRIDE_LG +: BANK_SEL_W];
  assign ofs      = bus_addr[BANK_STRIDE_LG-1:2];
  assign snap_off = bus_addr - SNAP_BASE;

  always_comb begin
    dec_op = OP_NONE;
    if (bus_wr_en && in_bank) begin
      if (ofs == OFS_W'(OFS_DRIVE_HI))
        dec_op = OP_HI;
      else if (ofs == OFS_W'(OFS_DRIVE_LO))
        dec_op = OP_LO;
      else if (ofs == OFS_W'(OFS_RELEASE))
        dec_op = OP_REL;
    end
  end

  // ---------------- one lane block per built bank ----------------
  for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank
    localparam int unsigned LO  = k * BANK_W;
    localparam int unsigned CNT = lanes_in_bank(NUM_PINS, LO, BANK_W);
    if (CNT > 0) begin : g_impl
      pin_op_e lane_op;
      assign lane_op = (bank_sel == BANK_SEL_W'(k)) ? dec_op : OP_NONE;

      pinbank_lane #(.LANES(CNT)) u_lane (
        .clk   (clk),
        .rst   (rst),
        .op    (lane_op),
        .mask  (bus_wdata[CNT-1:0]),
        .out_q (pin_out[LO +: CNT]),
        .oe_q  (pin_oe[LO +: CNT])
      );
    end
  end

  // ---------------- read path ----------------
  logic [REG_W-1:0] rd_word;

  always_comb begin
    rd_word = '0;
    if (in_bank) begin
      if (ofs == OFS_W'(OFS_DRIVE_HI))
        rd_word = sync_ext[int'(bank_sel) * BANK_W +: BANK_W];
    end else if (in_snap) begin
      rd_word = snap_ext[int'(snap_off >> 2) * BANK_W +: BANK_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd_en;
      if (bus_rd_en)
        bus_rdata <= rd_word;
    end
  end

endmodule

// File: rtl/pinbank_ctrl_chk.sv
module pinbank_ctrl_chk #(
  parameter int unsigned NUM_PINS = 75,
  parameter int unsigned ADDR_W   = 9,
  parameter int unsigned SNAP_W   = 64
) (
  input logic                clk,
  input logic                rst,
  input logic                bus_wr_en,
  input logic                bus_rd_en,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic                wr_bit0,
  input logic                bus_rvalid,
  input logic [NUM_PINS-1:0] pin_out,
  input logic [NUM_PINS-1:0] pin_oe,
  input logic                snap_done,
  input logic [SNAP_W-1:0]   snap_q
);

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (pin_oe == '0 && pin_out == '0 && !bus_rvalid)); // R1

  AST_DRIVE_HI: assert property (@(posedge clk) disable iff (rst)
    (bus_wr_en && bus_addr == ADDR_W'(0) && wr_bit0) |=> (pin_out[0] && pin_oe[0])); // R2

  AST_DRIVE_LO: assert property (@(posedge clk) disable iff (rst)
    (bus_wr_en && bus_addr == ADDR_W'(4) && wr_bit0) |=> (!pin_out[0] && pin_oe[0])); // R3

  AST_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (bus_wr_en && bus_addr == ADDR_W'(8) && wr_bit0) |=> (!pin_oe[0] && $stable(pin_out[0]))); // R4

  AST_RVALID_RISE: assert property (@(posedge clk) disable iff (rst)
    bus_rd_en |=> bus_rvalid); // R9

  AST_RVALID_IDLE: assert property (@(posedge clk) disable iff (rst)
    !bus_rd_en |=> !bus_rvalid); // R9

  AST_SNAP_FROZEN: assert property (@(posedge clk) disable iff (rst)
    snap_done |=> (snap_done && $stable(snap_q))); // R8

endmodule

bind pinbank_ctrl pinbank_ctrl_chk #(
  .NUM_PINS (NUM_PINS),
  .ADDR_W   (ADDR_W),
  .SNAP_W   (SNAP_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_wr_en  (bus_wr_en),
  .bus_rd_en  (bus_rd_en),
  .bus_addr   (bus_addr),
  .wr_bit0    (bus_wdata[0]),
  .bus_rvalid (bus_rvalid),
  .pin_out    (pin_out),
  .pin_oe     (pin_oe),
  .snap_done  (snap_done),
  .snap_q     (snap_q)
);

// File: tb/pinbank_ctrl_tb.sv
`timescale 1ns/1ps
module pinbank_ctrl_tb_top;

  localparam int NP = 75;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [8:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          rvalid;
  logic [NP-1:0] pin_in;
  logic [NP-1:0] pin_out;
  logic [NP-1:0] pin_oe;

  localparam logic [NP-1:0] BOOT_PAT = {11'h5A3, 64'hDEAD_BEEF_0123_4567};
  logic [NP-1:0] ext = BOOT_PAT;

  // bench-side model
  logic [NP-1:0] m_out = '0;
  logic [NP-1:0] m_oe  = '0;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  // pad model: a driven pin shows its latch, otherwise the external level
  assign pin_in = (pin_oe & pin_out) | (~pin_oe & ext);

  pinbank_ctrl dut_i (
    .clk(clk), .rst(rst), .bus_wr_en(wr_en), .bus_rd_en(rd_en),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .bus_rvalid(rvalid),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic chk32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_pins(input string tag);
    checks++;
    if (pin_out !== m_out || pin_oe !== m_oe) begin
      fails++;
      $display("FAIL %s actual out=%h oe=%h expected out=%h oe=%h",
               tag, pin_out, pin_oe, m_out, m_oe);
    end
  endtask

  function automatic void model_write(input logic [8:0] a, input logic [31:0] d);
    if (a < 9'h080) begin
      for (int j = 0; j < 32; j++) begin
        int p = int'(a[6:5]) * 32 + j;
        if (p < NP && d[j]) begin
          case (a[4:2])
            3'd0: begin m_out[p] = 1'b1; m_oe[p] = 1'b1; end
            3'd1: begin m_out[p] = 1'b0; m_oe[p] = 1'b1; end
            3'd2: m_oe[p] = 1'b0;
            default: ;
          endcase
        end
      end
    end
  endfunction

  function automatic logic [31:0] model_bank(input int k);
    logic [31:0] v = '0;
    for (int j = 0; j < 32; j++) begin
      int p = k * 32 + j;
      if (p < NP) v[j] = m_oe[p] ? m_out[p] : ext[p];
    end
    return v;
  endfunction

  task automatic bus_write(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
    model_write(a, d);
  endtask

  task automatic bus_read(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    chk32("R9 rvalid after read", {31'd0, rvalid}, 32'd1);
    d = rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    chk_pins("R1 reset state");
    chk32("R1 rvalid idle", {31'd0, rvalid}, 32'd0);
  endtask

  task automatic t_snapshot(input string tag);
    logic [31:0] d;
    bus_read(9'h100, d);
    chk32({tag, " low word"}, d, BOOT_PAT[31:0]);
    bus_read(9'h104, d);
    chk32({tag, " high word"}, d, BOOT_PAT[63:32]);
  endtask

  task automatic t_input_read(input logic [NP-1:0] pat);
    logic [31:0] d;
    ext = pat;
    settle();
    for (int k = 0; k < 3; k++) begin
      bus_read(9'(k * 32), d);
      chk32("R6 input levels", d, model_bank(k));
    end
  endtask

  task automatic t_drive_hi();
    logic [31:0] d;
    bus_write(9'h000, 32'h0000_00F0);
    chk_pins("R2 drive high sets pins 4-7");
    bus_write(9'h000, 32'h0000_0003);
    chk_pins("R2 zero bits untouched");
    settle();
    bus_read(9'h000, d);
    chk32("R6 output pins read back", d, model_bank(0));
  endtask

  task automatic t_drive_lo();
    bus_write(9'h004, 32'h0000_0130);
    chk_pins("R3 drive low on 4,5,8");
  endtask

  task automatic t_release();
    logic [31:0] d;
    bus_write(9'h008, 32'h0000_0011);
    chk_pins("R4 release keeps latch");
    settle();
    bus_read(9'h000, d);
    chk32("R4 released pin reads external", d, model_bank(0));
  endtask

  task automatic t_banks();
    bus_write(9'h020, 32'h0000_0008);
    chk_pins("R5 pin 35 in bank 1");
    bus_write(9'h040, 32'h0000_0400);
    chk_pins("R5 pin 74 in bank 2");
    bus_write(9'h024, 32'h0000_0008);
    chk_pins("R5 clear pin 35");
  endtask

  task automatic t_upper();
    logic [31:0] d;
    bus_write(9'h040, 32'hFFFF_FFFF);
    chk_pins("R7 bank 2 all ones");
    settle();
    bus_read(9'h040, d);
    chk32("R7 unbuilt bits read zero", d & 32'hFFFF_F800, 32'h0);
    bus_write(9'h060, 32'hFFFF_FFFF);
    chk_pins("R7 bank 3 write ignored");
    bus_read(9'h060, d);
    chk32("R7 bank 3 reads zero", d, 32'h0);
  endtask

  task automatic t_readmap();
    logic [31:0] d;
    bus_read(9'h004, d);
    chk32("R9 offset 0x04 reads zero", d, 32'h0);
    bus_read(9'h008, d);
    chk32("R9 offset 0x08 reads zero", d, 32'h0);
    bus_read(9'h180, d);
    chk32("R9 unmapped reads zero", d, 32'h0);
    @(negedge clk);
    chk32("R9 rvalid drops", {31'd0, rvalid}, 32'd0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    settle();
    t_snapshot("R8 boot capture");
    t_input_read({11'h2C7, 64'h0F0F_5555_A0A0_33CC});
    t_input_read({11'h13B, 64'h1234_5678_9ABC_DEF0});
    t_drive_hi();
    t_drive_lo();
    t_release();
    t_banks();
    t_upper();
    t_readmap();
    ext = ~BOOT_PAT;
    settle();
    t_snapshot("R8 frozen after change");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule